// File: doc/BRIEF.md
# DMA Channel Address and Count Register Set

This block holds the working state of one DMA channel: a current address, a current word count and a shadow copy of each, taken at the moment the CPU programs the channel. Each completed bus transfer is reported on a step input; the block moves the address one place up or down and takes one off the word count. When the count steps below zero, the block raises a terminal-count pulse and ends the service.

The end of a service comes from terminal count or from an external end-of-process input. What happens then depends on the mode. With autoinitialize on, the current registers are refilled from their shadow copies and the mask is left as it is. The channel can then run again with no CPU help. With autoinitialize off, the channel masks itself until the CPU clears the mask.

The block also decodes the programmed transfer type into the memory and I/O strobe pattern for a bus cycle in progress. It also produces a wait request from the ready input. A verify transfer keeps every strobe quiet and ignores ready. Bus timing and arbitration belong to neighbouring blocks.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the current and shadow registers read zero, the mask is set (1), the mode is zero (verify, incrementing, no autoinitialize), and every strobe and pulse output is inactive.
- R2: A CPU write with select 0 loads cpu_wdata into both the shadow and current address. Select 1 loads both word counts. Select 2 loads the mode: bits [1:0] are the type (00 verify, 01 write, 10 read, 11 treated as verify), bit 2 enables autoinitialize and bit 3 selects decrement. Select 3 loads the mask from bit 0.
- R3: A step while unmasked moves the current address by +1, or by -1 when mode bit 3 is set, and lowers the current count by one.
- R4: The shadow registers change only on a CPU write to their own select, never on a step or an end of process.
- R5: A step while unmasked with the current count at 0 wraps the count to all ones (0xFFFF at the default width). It also raises tc and eop_out for exactly the one following cycle.
- R6: With autoinitialize on, an end of process (terminal count or ext_eop while unmasked) copies both shadow registers into the current registers and leaves the mask clear.
- R7: With autoinitialize off, an end of process sets the mask and leaves the current registers at their stepped values.
- R8: While masked, step and ext_eop have no effect on the current registers, the mask or the pulse outputs.
- R9: While xfer_active is high, the write type drives mem_wr and io_rd, and the read type drives mem_rd and io_wr. No other strobe is active.
- R10: The verify type and the reserved type 11 keep all four strobes and wait_req inactive, whatever the value of ready.
- R11: For the write and read types, wait_req is high exactly when xfer_active is high and ready is low.
- R12: A CPU write takes precedence in its cycle. A step or ext_eop in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_sel | input | 2 | Register select: 0 address, 1 count, 2 mode, 3 mask |
| cpu_wdata | input | max(ADDR_W,CNT_W) | CPU write data |
| step | input | 1 | One transfer completed |
| ext_eop | input | 1 | External end of process |
| xfer_active | input | 1 | A bus cycle for this channel is in progress |
| ready | input | 1 | Addressed device is ready |
| cur_addr | output | ADDR_W | Current address |
| cur_count | output | CNT_W | Current word count |
| base_addr | output | ADDR_W | Shadow address |
| base_count | output | CNT_W | Shadow word count |
| mask | output | 1 | Channel mask |
| tc | output | 1 | Terminal-count pulse |
| eop_out | output | 1 | End-of-process pulse |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| wait_req | output | 1 | Wait-state request |

## Verification
The bench builds the block with its defaults: 16-bit address and count, and active-high strobes (STROBE_LOW = 0). With these values a count of 0 or 2 reaches the wrap to 0xFFFF within a few steps, so terminal count, both end-of-process paths and the decrement direction can all be reached in short sequences. The active-high polarity lets each strobe pattern be compared bit for bit against the type encoding.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   typedef enum logic [1:0] {
      XF_VERIFY = 2'b00,
      XF_WRITE  = 2'b01,
      XF_READ   = 2'b10,
      XF_RSVD   = 2'b11
   } xfer_t;

   typedef enum logic [1:0] {
      SEL_ADDR  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_MODE  = 2'd2,
      SEL_MASK  = 2'd3
   } sel_t;

   // bit 3 decrement, bit 2 autoinitialize, bits 1:0 transfer type
   typedef struct packed {
      logic  dec;
      logic  auto_en;
      xfer_t kind;
   } mode_t;

   // bit 3 mem_rd, bit 2 mem_wr, bit 1 io_rd, bit 0 io_wr
   typedef struct packed {
      logic mem_rd;
      logic mem_wr;
      logic io_rd;
      logic io_wr;
   } strobe_t;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   input  logic              dec,
   input  logic              reload,
   output logic [ADDR_W-1:0] cur,
   output logic [ADDR_W-1:0] base
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur  <= '0;
         base <= '0;
      end else if (load) begin
         cur  <= load_val;
         base <= load_val;
      end else if (reload) begin
         cur  <= base;
      end else if (step) begin
         cur  <= dec ? cur - ONE : cur + ONE;
      end
   end
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   input  logic             reload,
   output logic [CNT_W-1:0] cur,
   output logic [CNT_W-1:0] base,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign wrap = step && (cur == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur  <= '0;
         base <= '0;
      end else if (load) begin
         cur  <= load_val;
         base <= load_val;
      end else if (reload) begin
         cur  <= base;
      end else if (step) begin
         cur  <= cur - ONE;
      end
   end
endmodule

// File: rtl/dma_strobe_dec.sv
module dma_strobe_dec
   import dma_chan_pkg::*;
#(
   parameter bit STROBE_LOW = 1'b0
) (
   input  xfer_t       kind,
   input  logic        active,
   input  logic        ready,
   output logic [3:0]  stb_hi,
   output logic [3:0]  stb_pin,
   output logic        wait_req
);
   strobe_t s;
   logic    moves_data;

   always_comb begin
      s          = '0;
      moves_data = 1'b0;
      unique case (kind)
         XF_WRITE: begin
            s.mem_wr   = active;
            s.io_rd    = active;
            moves_data = 1'b1;
         end
         XF_READ: begin
            s.mem_rd   = active;
            s.io_wr    = active;
            moves_data = 1'b1;
         end
         default: ;
      endcase
   end

   assign stb_hi   = s;
   assign wait_req = moves_data && active && !ready;

   generate
      if (STROBE_LOW) begin : g_low
         assign stb_pin = ~stb_hi;
      end else begin : g_high
         assign stb_pin = stb_hi;
      end
   endgenerate
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 16,
   parameter bit STROBE_LOW = 1'b0,
   localparam int DATA_W    = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_en,
   input  logic [1:0]        cpu_sel,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              step,
   input  logic              ext_eop,
   input  logic              xfer_active,
   input  logic              ready,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_count,
   output logic [ADDR_W-1:0] base_addr,
   output logic [CNT_W-1:0]  base_count,
   output logic              mask,
   output logic              tc,
   output logic              eop_out,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr,
   output logic              wait_req
);
   generate
      if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
         $error("dma_chan_regs: ADDR_W must lie in 4..32");
      end
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_cnt
         $error("dma_chan_regs: CNT_W must lie in 4..32");
      end
   endgenerate

   mode_t      mode_q;
   logic       mask_q;
   logic       tc_q;
   logic       eop_q;
   logic       live;
   logic       eff_step;
   logic       wrap;
   logic       eop_now;
   logic       reload;
   logic       ld_addr;
   logic       ld_cnt;
   logic       auto_en_w;
   logic       dec_w;
   logic [1:0] kind_w;
   logic [3:0] stb_vec;
   logic [3:0] stb_pin;

   assign live      = !mask_q && !cpu_wr_en;
   assign eff_step  = live && step;
   assign eop_now   = live && (ext_eop || wrap);
   assign reload    = eop_now && mode_q.auto_en;
   assign ld_addr   = cpu_wr_en && (cpu_sel == SEL_ADDR);
   assign ld_cnt    = cpu_wr_en && (cpu_sel == SEL_COUNT);
   assign auto_en_w = mode_q.auto_en;
   assign dec_w     = mode_q.dec;
   assign kind_w    = mode_q.kind;

   dma_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_addr),
      .load_val (cpu_wdata[ADDR_W-1:0]),
      .step     (eff_step),
      .dec      (mode_q.dec),
      .reload   (reload),
      .cur      (cur_addr),
      .base     (base_addr)
   );

   dma_count_unit #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_cnt),
      .load_val (cpu_wdata[CNT_W-1:0]),
      .step     (eff_step),
      .reload   (reload),
      .cur      (cur_count),
      .base     (base_count),
      .wrap     (wrap)
   );

   dma_strobe_dec #(.STROBE_LOW(STROBE_LOW)) u_stb (
      .kind     (mode_q.kind),
      .active   (xfer_active),
      .ready    (ready),
      .stb_hi   (stb_vec),
      .stb_pin  (stb_pin),
      .wait_req (wait_req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         mask_q <= 1'b1;
         tc_q   <= 1'b0;
         eop_q  <= 1'b0;
      end else begin
         tc_q  <= wrap;
         eop_q <= eop_now;
         if (cpu_wr_en && cpu_sel == SEL_MODE) begin
            mode_q <= mode_t'(cpu_wdata[3:0]);
         end
         if (cpu_wr_en && cpu_sel == SEL_MASK) begin
            mask_q <= cpu_wdata[0];
         end else if (eop_now && !mode_q.auto_en) begin
            mask_q <= 1'b1;
         end
      end
   end

   assign mask    = mask_q;
   assign tc      = tc_q;
   assign eop_out = eop_q;
   assign mem_rd  = stb_pin[3];
   assign mem_wr  = stb_pin[2];
   assign io_rd   = stb_pin[1];
   assign io_wr   = stb_pin[0];
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr_en,
   input logic [1:0]        cpu_sel,
   input logic              step,
   input logic              ext_eop,
   input logic              xfer_active,
   input logic              ready,
   input logic              mask,
   input logic              auto_en,
   input logic              dec,
   input logic [1:0]        kind,
   input logic [3:0]        stb_vec,
   input logic              wait_req,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [CNT_W-1:0]  cur_count,
   input logic [ADDR_W-1:0] base_addr,
   input logic [CNT_W-1:0]  base_count,
   input logic              tc,
   input logic              eop_out
);
   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !mask && !cpu_wr_en && !ext_eop && cur_count != '0)
      |=> (cur_addr - $past(cur_addr) == ($past(dec) ? {ADDR_W{1'b1}} : ADDR_W'(1)))
          && ($past(cur_count) - cur_count == CNT_W'(1)));

   p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr_en && cpu_sel == 2'd0) |=> $stable(base_addr));

   p_base_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr_en && cpu_sel == 2'd1) |=> $stable(base_count));

   p_wrap_tc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !mask && !cpu_wr_en && cur_count == '0) |=> (tc && eop_out));

   p_auto_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eop_out && auto_en) |-> (cur_addr == base_addr && cur_count == base_count && !mask));

   p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eop_out && !auto_en) |-> mask);

   p_masked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask && !cpu_wr_en) |=> ($stable(cur_addr) && $stable(cur_count) && !tc && !eop_out));

   p_write_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 2'b01 && xfer_active) |-> (stb_vec == 4'b0110));

   p_read_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 2'b10 && xfer_active) |-> (stb_vec == 4'b1001));

   p_verify_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 2'b00 || kind == 2'b11) |-> (stb_vec == 4'b0000 && !wait_req));

   p_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == 2'b01 || kind == 2'b10) |-> (wait_req == (xfer_active && !ready)));

   p_one_hot_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> !tc);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_wr_en   (cpu_wr_en),
   .cpu_sel     (cpu_sel),
   .step        (step),
   .ext_eop     (ext_eop),
   .xfer_active (xfer_active),
   .ready       (ready),
   .mask        (mask),
   .auto_en     (auto_en_w),
   .dec         (dec_w),
   .kind        (kind_w),
   .stb_vec     (stb_vec),
   .wait_req    (wait_req),
   .cur_addr    (cur_addr),
   .cur_count   (cur_count),
   .base_addr   (base_addr),
   .base_count  (base_count),
   .tc          (tc),
   .eop_out     (eop_out)
);

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
   localparam int AW = 16;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cpu_wr_en, step, ext_eop, xfer_active, ready;
   logic [1:0]    cpu_sel;
   logic [15:0]   cpu_wdata;
   logic [AW-1:0] cur_addr, base_addr;
   logic [CW-1:0] cur_count, base_count;
   logic          mask, tc, eop_out, mem_rd, mem_wr, io_rd, io_wr, wait_req;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dma_chan_regs #(.ADDR_W(AW), .CNT_W(CW), .STROBE_LOW(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_sel(cpu_sel),
      .cpu_wdata(cpu_wdata), .step(step), .ext_eop(ext_eop),
      .xfer_active(xfer_active), .ready(ready), .cur_addr(cur_addr),
      .cur_count(cur_count), .base_addr(base_addr), .base_count(base_count),
      .mask(mask), .tc(tc), .eop_out(eop_out), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .wait_req(wait_req)
   );

   // op: 0..3 CPU write to that select, 4 step
   typedef struct packed {
      logic [2:0]  op;
      logic [15:0] data;
      logic [15:0] e_addr;
      logic [15:0] e_cnt;
      logic        e_mask;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 16'h1000, 16'h1000, 16'h0000, 1'b1}, // R2 address load
      '{3'd1, 16'h0002, 16'h1000, 16'h0002, 1'b1}, // R2 count load
      '{3'd2, 16'h0001, 16'h1000, 16'h0002, 1'b1}, // R2 mode write type, inc
      '{3'd4, 16'h0000, 16'h1000, 16'h0002, 1'b1}, // R8 masked step ignored
      '{3'd3, 16'h0000, 16'h1000, 16'h0002, 1'b0}, // R2 unmask
      '{3'd4, 16'h0000, 16'h1001, 16'h0001, 1'b0}, // R3 increment
      '{3'd4, 16'h0000, 16'h1002, 16'h0000, 1'b0}, // R3 increment
      '{3'd4, 16'h0000, 16'h1003, 16'hFFFF, 1'b1}, // R5 wrap, R7 mask set
      '{3'd4, 16'h0000, 16'h1003, 16'hFFFF, 1'b1}, // R8 masked step ignored
      '{3'd2, 16'h0009, 16'h1003, 16'hFFFF, 1'b1}, // R2 mode decrement
      '{3'd3, 16'h0000, 16'h1003, 16'hFFFF, 1'b0}, // R2 unmask
      '{3'd4, 16'h0000, 16'h1002, 16'hFFFE, 1'b0}  // R3 decrement
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      cpu_wr_en = 1'b0; cpu_sel = 2'd0; cpu_wdata = '0;
      step = 1'b0; ext_eop = 1'b0;
   endtask

   // drive at negedge, apply across one posedge, sample at the next negedge
   task automatic cyc(input logic wr, input logic [1:0] sel, input logic [15:0] d,
                      input logic st, input logic ee);
      @(negedge clk);
      cpu_wr_en = wr; cpu_sel = sel; cpu_wdata = d; step = st; ext_eop = ee;
      @(negedge clk);
      idle();
   endtask

   task automatic cpu(input logic [1:0] sel, input logic [15:0] d);
      cyc(1'b1, sel, d, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      rst_n = 1'b0; xfer_active = 1'b0; ready = 1'b1;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 addr", cur_addr, 0);
      chk("R1 count", cur_count, 0);
      chk("R1 base", {base_addr, base_count}, 0);
      chk("R1 mask", mask, 1);
      chk("R1 pulses", {tc, eop_out}, 0);
      xfer_active = 1'b1; ready = 1'b0;
      #1;
      chk("R1 strobes", {mem_rd, mem_wr, io_rd, io_wr, wait_req}, 0);
      xfer_active = 1'b0; ready = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         if (VECS[i].op == 3'd4) cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
         else cpu(VECS[i].op[1:0], VECS[i].data);
         chk($sformatf("vec%0d addr R2/R3/R8", i), cur_addr, VECS[i].e_addr);
         chk($sformatf("vec%0d count R3/R5", i), cur_count, VECS[i].e_cnt);
         chk($sformatf("vec%0d mask R7/R8", i), mask, VECS[i].e_mask);
      end

      // R4 shadows untouched by steps and end of process
      chk("R4 base addr", base_addr, 16'h1000);
      chk("R4 base count", base_count, 16'h0002);

      // R5 pulse for exactly one cycle after a wrap (autoinit off)
      cpu(2'd2, 16'h0001);
      cpu(2'd1, 16'h0000);
      cpu(2'd3, 16'h0000);
      cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
      chk("R5 tc", tc, 1);
      chk("R5 eop", eop_out, 1);
      chk("R5 wrap", cur_count, 16'hFFFF);
      @(negedge clk);
      chk("R5 tc one cycle", {tc, eop_out}, 0);

      // R6 autoinit on terminal count
      cpu(2'd2, 16'h0005);
      cpu(2'd0, 16'h2000);
      cpu(2'd1, 16'h0001);
      cpu(2'd3, 16'h0000);
      cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
      chk("R6 pre addr", cur_addr, 16'h2001);
      cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
      chk("R6 tc", tc, 1);
      chk("R6 reload addr", cur_addr, 16'h2000);
      chk("R6 reload count", cur_count, 16'h0001);
      chk("R6 mask clear", mask, 0);
      // R6 external end of process
      cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
      cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1);
      chk("R6 ext eop pulse", {eop_out, tc}, 2'b10);
      chk("R6 ext reload", {cur_addr, cur_count}, {16'h2000, 16'h0001});
      chk("R6 ext mask", mask, 0);

      // R7 external end of process with autoinit off
      cpu(2'd2, 16'h0001);
      cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
      cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1);
      chk("R7 mask set", mask, 1);
      chk("R7 keep", {cur_addr, cur_count}, {16'h2001, 16'h0000});

      // R8 masked ext_eop has no effect
      cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1);
      chk("R8 no pulse", {eop_out, tc}, 0);
      chk("R8 hold", {cur_addr, cur_count}, {16'h2001, 16'h0000});

      // R12 CPU write wins over a step
      cpu(2'd3, 16'h0000);
      cyc(1'b1, 2'd0, 16'h3000, 1'b1, 1'b0);
      chk("R12 addr", cur_addr, 16'h3000);
      chk("R12 count", cur_count, 16'h0000);
      chk("R12 no tc", tc, 0);

      // R9 / R10 / R11 strobe patterns
      for (int t = 0; t < 4; t++) begin
         cpu(2'd2, 16'(t));
         for (int a = 0; a < 2; a++) begin
            for (int r = 0; r < 2; r++) begin
               logic [3:0] exp_s;
               logic       exp_w;
               xfer_active = a[0]; ready = r[0];
               #1;
               exp_s = 4'b0000;
               if (a == 1 && t == 1) exp_s = 4'b0110;
               if (a == 1 && t == 2) exp_s = 4'b1001;
               exp_w = (t == 1 || t == 2) && a == 1 && r == 0;
               chk($sformatf("R9 R10 strobes type%0d", t), {mem_rd, mem_wr, io_rd, io_wr}, exp_s);
               chk($sformatf("R10 R11 wait type%0d", t), wait_req, exp_w);
            end
         end
         xfer_active = 1'b0; ready = 1'b1;
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule